// File: doc/BRIEF.md
# Embedded-Sync Video Frame Capture Front End

This block sits on the sampling clock of a video decoder that delivers an 8-bit, 4:2:2 component stream. The stream has no separate sync wires: its timing is carried by reference codes embedded in the byte stream. The block follows the line and field structure from those codes and keeps track of the current field, of vertical blanking and of horizontal blanking.

A capture request comes from a push button. The request is synchronised into the video clock domain and only its rising edge counts. After a request, the block waits for the first active line of field 0 that follows a vertical blanking interval. It then forwards every active-video byte of field 0 and field 1, which together make one frame, into the write port of a FIFO, and stops after that single frame.

Each FIFO word carries the pixel byte together with three framing tags: a field bit, a start-of-line flag and a start-of-frame flag. If the FIFO reports full when a byte is due to be written, that byte is dropped and a sticky overflow flag is raised.

Top module: `bt656_capture`

## Requirements
- R1: A timing reference is recognised only as the byte run FF, 00, 00 followed by a status byte whose bit 7 is 1. In the status byte, bit 6 is the field (F), bit 5 is vertical blanking (V) and bit 4 is H (1 marks end-of-active-video, 0 marks start-of-active-video). A run whose fourth byte has bit 7 at 0 is not a reference.
- R2: The only bytes written are those that follow a start-of-active-video reference with V=0, up to the next reference. Reference bytes and blanking bytes are never written.
- R3: A FIFO word is {sof, sol, field, data}, with data in bits 7:0, field in bit 8, sol in bit 9 and sof in bit 10. The field bit is the F of the line's start reference, and sol is 1 exactly on the first byte of each captured line.
- R4: sof is 1 only on the first byte of a captured frame. That word also has sol at 1.
- R5: Nothing is written without a request. A request held high over several frames starts exactly one capture.
- R6: After a request, capture begins at the first field-0 active line that follows a vertical-blanking reference. A field-0 line still in progress when the request arrives is skipped, and so is the rest of that field.
- R7: Capture stops at the first vertical-blanking reference that follows an active line of field 1. A frame is therefore exactly one field-0 pass plus one field-1 pass.
- R8: A new request edge that arrives while a capture is armed or running has no effect.
- R9: A byte that is due while fifo_full is high is dropped, and overflow goes to 1. overflow stays at 1 until the next accepted request or a reset.
- R10: While reset is high and just after it, fifo_we and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_byte | input | PIX_W | Incoming video stream byte |
| cap_req | input | 1 | Asynchronous capture request (push button level) |
| fifo_full | input | 1 | FIFO full indication |
| fifo_we | output | 1 | FIFO write enable, registered |
| fifo_wdata | output | PIX_W+3 | {sof, sol, field, data}, registered |
| overflow | output | 1 | Sticky flag for dropped bytes |

## Verification
Two functions can fall on the same byte: the start-of-frame tag and the overflow drop. They collide when the FIFO is full during the first line of a capture. The bench provokes this by holding fifo_full across exactly that line, on a frame it has armed from a blanking line. It judges the result by checking three things: no word of that line reaches the FIFO, overflow rises, and no later word of the frame carries sof. The bench's own line-level model predicts that outcome.

// File: rtl/bt656_pkg.sv
package bt656_pkg;
  // capture sequencer states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } cap_state_e;

  // number of preamble bytes ahead of a reference status byte
  localparam int TRS_PRE_LEN = 3;

  // tag offsets above the data field of a FIFO word
  localparam int TAG_FLD = 0;
  localparam int TAG_SOL = 1;
  localparam int TAG_SOF = 2;
  localparam int TAG_W   = 3;
endpackage

// File: rtl/bt656_req_sync.sv
module bt656_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic req_pulse
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= req_async;
  end

  for (genvar s = 1; s < CHAIN; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= 1'b0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign req_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R5: a held level yields a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    req_pulse |=> !req_pulse);
endmodule

// File: rtl/bt656_trs_decoder.sv
module bt656_trs_decoder import bt656_pkg::*; #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] vid_in,
  output logic             trs_hit,
  output logic             trs_f,
  output logic             trs_v,
  output logic             trs_h,
  output logic             pix_valid,
  output logic             pix_sol,
  output logic             pix_field,
  output logic [PIX_W-1:0] pix_data
);
  localparam int F_POS = PIX_W - 2;
  localparam int V_POS = PIX_W - 3;
  localparam int H_POS = PIX_W - 4;
  localparam int KC_W  = $clog2(TRS_PRE_LEN + 1);
  localparam logic [PIX_W-1:0] ALL1 = {PIX_W{1'b1}};
  localparam logic [PIX_W-1:0] ALL0 = {PIX_W{1'b0}};
  localparam logic [KC_W-1:0]  KC_LOAD = KC_W'(TRS_PRE_LEN);

  // d1 newest, d3 oldest; d3 is the byte offered downstream
  logic [PIX_W-1:0] d1_q, d2_q, d3_q;
  logic [KC_W-1:0]  kill_q;
  logic             line_act_q;
  logic             sol_pend_q;
  logic             fld_q;

  assign trs_hit = (d3_q == ALL1) && (d2_q == ALL0) && (d1_q == ALL0) && vid_in[PIX_W-1];
  assign trs_f   = vid_in[F_POS];
  assign trs_v   = vid_in[V_POS];
  assign trs_h   = vid_in[H_POS];

  assign pix_valid = line_act_q && (kill_q == '0) && !trs_hit;
  assign pix_data  = d3_q;
  assign pix_sol   = sol_pend_q;
  assign pix_field = fld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      d1_q       <= '0;
      d2_q       <= '0;
      d3_q       <= '0;
      kill_q     <= '0;
      line_act_q <= 1'b0;
      sol_pend_q <= 1'b0;
      fld_q      <= 1'b0;
    end else begin
      d1_q <= vid_in;
      d2_q <= d1_q;
      d3_q <= d2_q;
      if (trs_hit) begin
        kill_q <= KC_LOAD;
        if (!trs_h && !trs_v) begin
          line_act_q <= 1'b1;
          sol_pend_q <= 1'b1;
          fld_q      <= trs_f;
        end else begin
          line_act_q <= 1'b0;
        end
      end else begin
        if (kill_q != '0) kill_q <= kill_q - 1'b1;
        if (pix_valid) sol_pend_q <= 1'b0;
      end
    end
  end

  // R2: the bytes trailing a detected preamble never leave as pixels
  a_r2_ref_not_forwarded: assert property (@(posedge clk) disable iff (rst)
    trs_hit |=> !pix_valid);
  // R1: a start reference for an active line opens a line with sol pending
  a_r1_sav_opens_line: assert property (@(posedge clk) disable iff (rst)
    (trs_hit && !trs_h && !trs_v) |=> (pix_sol && !pix_valid));
endmodule

// File: rtl/bt656_frame_ctrl.sv
module bt656_frame_ctrl import bt656_pkg::*; #(
  parameter int PIX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_pulse,
  input  logic                   trs_hit,
  input  logic                   trs_f,
  input  logic                   trs_v,
  input  logic                   trs_h,
  input  logic                   pix_valid,
  input  logic                   pix_sol,
  input  logic                   pix_field,
  input  logic [PIX_W-1:0]       pix_data,
  input  logic                   fifo_full,
  output logic                   fifo_we,
  output logic [PIX_W+TAG_W-1:0] fifo_wdata,
  output logic                   overflow
);
  cap_state_e st_q;
  logic       blank_seen_q;
  logic       seen_f1_q;
  logic       first_q;
  logic       wr_try;
  logic       is_sav;

  assign is_sav = trs_hit && !trs_h && !trs_v;
  assign wr_try = (st_q == ST_RUN) && pix_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      blank_seen_q <= 1'b0;
      seen_f1_q    <= 1'b0;
      first_q      <= 1'b0;
      overflow     <= 1'b0;
      fifo_we      <= 1'b0;
      fifo_wdata   <= '0;
    end else begin
      fifo_we    <= wr_try && !fifo_full;
      fifo_wdata <= {first_q, pix_sol, pix_field, pix_data};
      if (wr_try) begin
        first_q <= 1'b0;
        if (fifo_full) overflow <= 1'b1;
      end
      case (st_q)
        ST_IDLE: begin
          if (start_pulse) begin
            st_q         <= ST_ARM;
            blank_seen_q <= 1'b0;
            overflow     <= 1'b0;
          end
        end
        ST_ARM: begin
          if (trs_hit && trs_v) begin
            blank_seen_q <= 1'b1;
          end else if (is_sav) begin
            if (trs_f) begin
              blank_seen_q <= 1'b0;
            end else if (blank_seen_q) begin
              st_q      <= ST_RUN;
              first_q   <= 1'b1;
              seen_f1_q <= 1'b0;
            end
          end
        end
        ST_RUN: begin
          if (trs_hit && trs_v && seen_f1_q) st_q <= ST_IDLE;
          if (is_sav && trs_f) seen_f1_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9: no write is issued in a cycle decided while full was high
  a_r9_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> !$past(fifo_full));
  // R9: overflow only falls on an accepted request
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (overflow && !(st_q == ST_IDLE && start_pulse)) |=> overflow);
  // R4: a start-of-frame word always opens a line
  a_r4_sof_has_sol: assert property (@(posedge clk) disable iff (rst)
    (fifo_we && fifo_wdata[PIX_W+TAG_SOF]) |-> fifo_wdata[PIX_W+TAG_SOL]);
  // R5: an idle sequencer writes nothing
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> !fifo_we);
  // R8: a request edge during a capture does not re-arm
  a_r8_busy_ignores_req: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && start_pulse) |=> st_q != ST_ARM);
endmodule

// File: rtl/bt656_capture.sv
module bt656_capture import bt656_pkg::*; #(
  parameter int PIX_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PIX_W-1:0]       vid_byte,
  input  logic                   cap_req,
  input  logic                   fifo_full,
  output logic                   fifo_we,
  output logic [PIX_W+TAG_W-1:0] fifo_wdata,
  output logic                   overflow
);
  logic             start_pulse;
  logic             trs_hit, trs_f, trs_v, trs_h;
  logic             pix_valid, pix_sol, pix_field;
  logic [PIX_W-1:0] pix_data;

  bt656_req_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
    .clk       (clk),
    .rst       (rst),
    .req_async (cap_req),
    .req_pulse (start_pulse)
  );

  bt656_trs_decoder #(.PIX_W(PIX_W)) decoder_i (
    .clk       (clk),
    .rst       (rst),
    .vid_in    (vid_byte),
    .trs_hit   (trs_hit),
    .trs_f     (trs_f),
    .trs_v     (trs_v),
    .trs_h     (trs_h),
    .pix_valid (pix_valid),
    .pix_sol   (pix_sol),
    .pix_field (pix_field),
    .pix_data  (pix_data)
  );

  bt656_frame_ctrl #(.PIX_W(PIX_W)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .start_pulse (start_pulse),
    .trs_hit     (trs_hit),
    .trs_f       (trs_f),
    .trs_v       (trs_v),
    .trs_h       (trs_h),
    .pix_valid   (pix_valid),
    .pix_sol     (pix_sol),
    .pix_field   (pix_field),
    .pix_data    (pix_data),
    .fifo_full   (fifo_full),
    .fifo_we     (fifo_we),
    .fifo_wdata  (fifo_wdata),
    .overflow    (overflow)
  );

  // R10: outputs are quiet in the cycle after reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!fifo_we && !overflow));
endmodule

// File: tb/bt656_capture_tb_top.sv
module bt656_capture_tb_top;
  localparam int NB = 2;  // blanking lines per field
  localparam int NA = 3;  // active lines per field
  localparam int WATCHDOG = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  vid_byte = 8'h10;
  logic        cap_req = 1'b0;
  logic        fifo_full = 1'b0;
  logic        fifo_we;
  logic [10:0] fifo_wdata;
  logic        overflow;

  always #10 clk = ~clk;

  bt656_capture dut_i (
    .clk        (clk),
    .rst        (rst),
    .vid_byte   (vid_byte),
    .cap_req    (cap_req),
    .fifo_full  (fifo_full),
    .fifo_we    (fifo_we),
    .fifo_wdata (fifo_wdata),
    .overflow   (overflow)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [10:0] got_q[$];
  logic [10:0] exp_q[$];

  // line-level model state: 0 idle, 1 armed, 2 running
  int m_st = 0;
  bit m_blank = 0, m_f1 = 0, m_first = 0, exp_ovf = 0, req_prev = 0;
  bit cur_req = 0;

  always @(negedge clk) if (!rst && fifo_we) got_q.push_back(fifo_wdata);

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] xy(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    vid_byte = b;
  endtask

  task automatic model_req(input bit lvl);
    if (lvl && !req_prev && m_st == 0) begin
      m_st = 1; m_blank = 0; exp_ovf = 0;
    end
    req_prev = lvl;
  endtask

  task automatic model_ref(input bit f, input bit v, input bit h);
    if (m_st == 1) begin
      if (v) m_blank = 1;
      else if (!h) begin
        if (f) m_blank = 0;
        else if (m_blank) begin m_st = 2; m_first = 1; m_f1 = 0; end
      end
    end else if (m_st == 2) begin
      if (v && m_f1) m_st = 0;
      else if (!v && !h && f) m_f1 = 1;
    end
  endtask

  task automatic send_line(input bit f, input bit v, input bit full_on);
    int n;
    logic [7:0] b;
    @(negedge clk);
    cap_req = cur_req;
    fifo_full = full_on;
    model_req(cur_req);
    for (int i = 0; i < 4; i++) put(8'h10);
    put(8'hFF); put(8'h00); put(8'h00); put(xy(f, v, 1'b0));
    model_ref(f, v, 1'b0);
    n = 2 * int'($urandom_range(2, 6));
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom_range(1, 254));
      put(b);
      if (m_st == 2 && !v) begin
        if (full_on) exp_ovf = 1;
        else exp_q.push_back({m_first, (i == 0), f, b});
        m_first = 0;
      end
    end
    put(8'hFF); put(8'h00); put(8'h00); put(xy(f, v, 1'b1));
    model_ref(f, v, 1'b1);
    // look-alike preamble with status bit 7 clear: not a reference (R1)
    put(8'h80); put(8'hFF); put(8'h00); put(8'h00); put(8'h0C); put(8'h80);
  endtask

  // req_at / rel_at / full_at: line index inside the field, -1 for none
  task automatic send_field(input bit f, input int req_at, input int rel_at, input int full_at);
    for (int l = 0; l < NB + NA; l++) begin
      if (l == req_at) cur_req = 1;
      if (l == rel_at) cur_req = 0;
      send_line(f, (l < NB), (l == full_at));
    end
  endtask

  task automatic compare(input string tag);
    check(got_q.size() == exp_q.size(), {tag, " word count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] === exp_q[i], {tag, " word"}, int'(got_q[i]), int'(exp_q[i]));
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R5 actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(fifo_we === 1'b0, "R10 fifo_we in reset", fifo_we, 0);
    check(overflow === 1'b0, "R10 overflow in reset", overflow, 0);
    rst = 1'b0;
    @(negedge clk);
    check(fifo_we === 1'b0 && overflow === 1'b0, "R10 after reset", {fifo_we, overflow}, 0);

    // no request: nothing written (R5, R1 look-alikes ignored)
    send_field(0, -1, -1, -1); send_field(1, -1, -1, -1);
    compare("R5 R1 no request");

    // request mid field 0 active, held for several frames (R6, R5, R2, R3, R4, R7)
    send_field(0, NB + 1, -1, -1); send_field(1, -1, -1, -1);
    send_field(0, -1, -1, -1); send_field(1, -1, -1, -1);
    send_field(0, -1, -1, -1); send_field(1, -1, NB, -1);
    send_field(0, -1, -1, -1); send_field(1, -1, -1, -1);
    check(exp_q.size() > 0, "R6 model captured a frame", exp_q.size(), 1);
    compare("R2 R3 R4 R6 R7 held request");
    check(overflow === 1'b0, "R9 no overflow", overflow, 0);

    // request during field 1, full on one line of the captured field 1 (R9)
    send_field(0, -1, -1, -1); send_field(1, NB, NB + 2, -1);
    send_field(0, -1, -1, -1); send_field(1, -1, -1, NB + 1);
    send_field(0, -1, -1, -1);
    compare("R9 R6 drop mid frame");
    check(overflow === bit'(exp_ovf), "R9 overflow set", overflow, exp_ovf);
    check(overflow === 1'b1, "R9 overflow sticky", overflow, 1);

    // request on a blanking line; first captured line dropped (sof collision),
    // second press during field 1 ignored (R8)
    send_field(1, -1, -1, -1);
    cur_req = 1;
    send_line(0, 1, 0);
    check(overflow === 1'b0, "R9 cleared by accepted request", overflow, 0);
    cur_req = 0;
    send_line(0, 1, 0);
    send_line(0, 0, 1);
    send_line(0, 0, 0); send_line(0, 0, 0);
    send_field(1, NB + 1, NB + 2, -1);
    send_field(0, -1, -1, -1); send_field(1, -1, -1, -1);
    compare("R4 R8 R9 sof collision");
    check(overflow === 1'b1, "R9 overflow after first-line drop", overflow, 1);
    finish_run();
  end
endmodule